// File: doc/BRIEF.md
# Three-Lane 7:1 Display Link Serializer

This block turns one 21-bit parallel pixel word per pixel clock into three serial data lanes and one forwarded clock lane. A typical word holds 18 colour bits and three timing bits: line sync, frame sync and data-ready. The word is captured on the rising edge of the pixel clock. During the next pixel period each lane sends seven bits of it, one bit per cycle of an external bit clock. That bit clock runs at seven times the pixel rate and is phase-aligned to it. The pixel clock may run anywhere from 20 to 65 MHz, so at the top rate each lane carries 455 Mbit/s.

The clock lane repeats a fixed seven-slot pattern. It goes high at slot 0, so a receiver can find the word boundary from its rising edge. An active-low power-down input disables all serial outputs. The enable output `ser_oe_o` models the high-impedance state of the pads. When power-down is released, the slot counter re-aligns to the pixel clock. The outputs stay disabled until the first word captured after release has been loaded.

Top module: `fpd_link_ser`

## Requirements
- R1: When `pd_n` is high, all 21 bits of `pix_i` are captured on each rising edge of `pclk`. When `pd_n` is low, no word is captured for transmission.
- R2: Data lane 0 carries word bits [6:0], lane 1 carries bits [13:7] and lane 2 carries bits [20:14].
- R3: Within each lane, word bit 7*lane+k is sent in slot k. Slot k spans bit-clock cycle k after the pixel edge, so the LSB goes out first in slot 0.
- R4: While enabled, the clock lane is 1 in slots 0 to 3 and 0 in slots 4 to 6, which gives a rising edge at each word boundary.
- R5: A word captured at pixel edge E starts on the serial lanes at the following pixel edge, one pixel period after E.
- R6: When `pd_n` is sampled low on a bit-clock edge, `ser_oe_o` goes low at that edge. All serial outputs then read 0 (modelled high-impedance) until power-down is released.
- R7: After `pd_n` returns high, the slot counter is re-aligned to the pixel clock. `ser_oe_o` stays low until the first word captured after release is loaded, and that word is the first one sent.
- R8: While enabled and out of power-down, consecutive words follow each other with no gap, seven slots per pixel period. No word is lost, repeated or inserted.
- R9: While `rst_n` is low, `ser_oe_o` and all serial outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Pixel clock |
| bclk | input | 1 | Bit clock, 7x pixel rate, rising edges aligned to pclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| pix_i | input | 21 | Parallel pixel word |
| ser_data_o | output | 3 | Serial data lanes, bit n is lane n |
| ser_clk_o | output | 1 | Forwarded clock-pattern lane |
| ser_oe_o | output | 1 | Output enable; low models high impedance |

## Verification
Two events can fall on the same bit-clock edge: the load of a new word at slot 0, and the sampling of a power-down request. The bench provokes this by dropping `pd_n` just after a pixel edge, while the previously captured word has just begun to shift out. The expected result is that only slot 0 of that word appears and the enable drops at the next bit edge. The scoreboard discards the truncated word. The oe check at each pixel edge and the queue contents show that the partial word and the words captured around power-down are never delivered. One-period and multi-period power-down pulses are also used. These show that the restart sends, first and at the right edge, the word captured just after release.

// File: rtl/fpd_ser_pkg.sv
package fpd_ser_pkg;
  // Sequencer states of the bit-clock domain
  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_SEEK = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fpd_capture.sv
module fpd_capture #(
  parameter int unsigned WORD_W = 21
) (
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic [WORD_W-1:0] d_i,
  output logic [WORD_W-1:0] hold_o,
  output logic              vld_o,
  output logic              tog_o
);
  logic [WORD_W-1:0] hold_d;

  // Capture enable is the power-down input itself
  always_comb begin
    hold_d = hold_o;
    if (pd_n) hold_d = d_i;
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_o <= '0;
      vld_o  <= 1'b0;
      tog_o  <= 1'b0;
    end else begin
      hold_o <= hold_d;
      vld_o  <= pd_n;
      tog_o  <= ~tog_o;
    end
  end

  // R1
  cap_valid_pd_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    !pd_n |=> !vld_o);
endmodule

// File: rtl/fpd_slot_ctl.sv
module fpd_slot_ctl
  import fpd_ser_pkg::*;
#(
  parameter int unsigned SLOTS  = 7,
  parameter int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic              tog_i,
  input  logic              vld_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              load_o,
  output logic              oe_o,
  output logic              clr_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  seq_state_e        st_q, st_d;
  logic [SLOT_W-1:0] slot_d;
  logic              oe_d;
  logic              tog_q;
  logic              mark;

  // High between a pixel edge and the following bit edge
  assign mark  = tog_i ^ tog_q;
  assign clr_o = ~pd_n;

  always_comb begin
    st_d   = st_q;
    slot_d = slot_o;
    oe_d   = oe_o;
    load_o = 1'b0;
    if (!pd_n) begin
      st_d   = SEQ_OFF;
      slot_d = '0;
      oe_d   = 1'b0;
    end else begin
      unique case (st_q)
        SEQ_OFF:  st_d = SEQ_SEEK;
        SEQ_SEEK: if (mark) begin
          st_d   = SEQ_RUN;
          slot_d = SLOT_W'(1);
        end
        SEQ_RUN: begin
          if (slot_o == LAST_SLOT) begin
            slot_d = '0;
            load_o = 1'b1;
            oe_d   = oe_o | vld_i;
          end else begin
            slot_d = slot_o + SLOT_W'(1);
          end
        end
        default: st_d = SEQ_OFF;
      endcase
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_OFF;
      slot_o <= '0;
      oe_o   <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      slot_o <= slot_d;
      oe_o   <= oe_d;
      tog_q  <= tog_i;
    end
  end

  // R5
  slot_align_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (st_q == SEQ_RUN && mark) |-> (slot_o == '0));

  // R6
  oe_pd_off_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    !pd_n |=> !oe_o);

  // R7
  oe_rise_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(oe_o) |-> ($past(slot_o) == LAST_SLOT && $past(vld_i) && slot_o == '0));

  // R8
  slot_range_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    slot_o <= LAST_SLOT);
endmodule

// File: rtl/fpd_lane_shift.sv
module fpd_lane_shift #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [SLOTS-1:0] par_i,
  output logic             bit_o
);
  logic [SLOTS-1:0] sr_q, sr_d;

  always_comb begin
    if (clr_i)       sr_d = '0;
    else if (load_i) sr_d = par_i;
    else             sr_d = sr_q >> 1;
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign bit_o = sr_q[0];

  // R6
  lane_clear_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    clr_i |=> !bit_o);
endmodule

// File: rtl/fpd_link_ser.sv
module fpd_link_ser #(
  parameter int unsigned         LANES   = 3,
  parameter int unsigned         SLOTS   = 7,
  parameter logic [SLOTS-1:0]    CLK_PAT = 7'b0001111,
  parameter int unsigned         WORD_W  = LANES * SLOTS
) (
  input  logic              pclk,
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              pd_n,
  input  logic [WORD_W-1:0] pix_i,
  output logic [LANES-1:0]  ser_data_o,
  output logic              ser_clk_o,
  output logic              ser_oe_o
);
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [WORD_W-1:0] hold;
  logic              vld;
  logic              tog;
  logic [SLOT_W-1:0] slot;
  logic              load;
  logic              oe;
  logic              clr;
  logic [LANES-1:0]  lane_bit;

  fpd_capture #(.WORD_W(WORD_W)) cap_i (
    .pclk   (pclk),
    .rst_n  (rst_n),
    .pd_n   (pd_n),
    .d_i    (pix_i),
    .hold_o (hold),
    .vld_o  (vld),
    .tog_o  (tog)
  );

  fpd_slot_ctl #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) seq_i (
    .bclk   (bclk),
    .rst_n  (rst_n),
    .pd_n   (pd_n),
    .tog_i  (tog),
    .vld_i  (vld),
    .slot_o (slot),
    .load_o (load),
    .oe_o   (oe),
    .clr_o  (clr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fpd_lane_shift #(.SLOTS(SLOTS)) lane_i (
      .bclk   (bclk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .load_i (load),
      .par_i  (hold[g*SLOTS +: SLOTS]),
      .bit_o  (lane_bit[g])
    );
    assign ser_data_o[g] = oe & lane_bit[g];
  end

  assign ser_clk_o = oe & CLK_PAT[slot];
  assign ser_oe_o  = oe;
endmodule

// File: tb/fpd_link_ser_tb_top.sv
module fpd_link_ser_tb_top;
  localparam int LANES = 3;
  localparam int SLOTS = 7;
  localparam int W     = LANES * SLOTS;

  logic             pclk, bclk, rst_n, pd_n;
  logic [W-1:0]     pix;
  logic [LANES-1:0] sd;
  logic             sc, soe;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] expq[$];

  // scoreboard driver history
  logic         pp1, pp2;
  logic [W-1:0] pw1, pw2;

  // monitor state
  int           mslot = 0;
  logic [SLOTS-1:0] lb [LANES];
  logic [W-1:0] wexp;

  initial begin
    bclk = 1'b0;
    pclk = 1'b0;
    for (int k = 0; ; k = (k + 1) % SLOTS) begin
      #4;
      bclk = 1'b1;
      pclk = (k < 4);
      #4;
      bclk = 1'b0;
    end
  end

  fpd_link_ser dut_i (
    .pclk       (pclk),
    .bclk       (bclk),
    .rst_n      (rst_n),
    .pd_n       (pd_n),
    .pix_i      (pix),
    .ser_data_o (sd),
    .ser_clk_o  (sc),
    .ser_oe_o   (soe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: mid-bit sampling on falling bit-clock edges
  always @(negedge bclk) begin
    if (soe) begin
      // R4 clock lane pattern
      chk(sc == (mslot < 4), "R4 clock lane slot", int'(sc), int'(mslot < 4));
      for (int l = 0; l < LANES; l++) lb[l][mslot] = sd[l];
      mslot++;
      if (mslot == SLOTS) begin
        mslot = 0;
        if (expq.size() == 0) begin
          chk(1'b0, "R8 unexpected word", 1, 0);
        end else begin
          wexp = expq.pop_front();
          for (int l = 0; l < LANES; l++)
            chk(lb[l] == wexp[l*SLOTS +: SLOTS], "R1 R2 R3 lane bits",
                int'(lb[l]), int'(wexp[l*SLOTS +: SLOTS]));
        end
      end
    end else begin
      mslot = 0;  // partial word dropped
      // R6 R9 outputs quiet while disabled
      chk(sd == '0 && sc == 1'b0, "R6 outputs idle", int'({sc, sd}), 0);
    end
  end

  // Driver: one pixel period per call
  task automatic run_period(input logic [W-1:0] word, input logic pd);
    @(posedge pclk);
    #2;
    // R5 R7 enable state during slot 0 of this period
    chk(soe == (pp1 & pp2), "R5 R7 oe at word boundary", int'(soe), int'(pp1 & pp2));
    if (pp2 & pp1 & pd) expq.push_back(pw2);
    pp2 = pp1;
    pp1 = pd;
    pw2 = pw1;
    pw1 = word;
    pix  = word;
    pd_n = pd;
  endtask

  function automatic logic [W-1:0] mix(input int i);
    logic [31:0] h;
    h = (i + 7) * 32'h9E37_79B1;
    return h[W+4:5];
  endfunction

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pd_n  = 1'b0;
    pix   = '0;
    pp1 = 1'b0; pp2 = 1'b0; pw1 = '0; pw2 = '0;
    #20;
    // R9 reset state
    chk(soe == 1'b0 && sd == '0 && sc == 1'b0, "R9 reset outputs", int'({soe, sc, sd}), 0);
    #41 rst_n = 1'b1;
    run_period('1, 1'b0);
    run_period('1, 1'b0);
    // walking one (R1 R2 R3)
    for (int i = 0; i < W; i++) run_period(W'(1) << i, 1'b1);
    run_period('1, 1'b1);
    run_period('0, 1'b1);
    run_period(21'h155555, 1'b1);
    run_period(21'h0AAAAA, 1'b1);
    for (int i = 0; i < 20; i++) run_period(mix(i), 1'b1);
    // one-period power-down landing on a word load (R6 R7)
    run_period(21'h1F0F0F, 1'b0);
    for (int i = 20; i < 30; i++) run_period(mix(i), 1'b1);
    // longer power-down
    for (int i = 0; i < 5; i++) run_period(mix(100 + i), 1'b0);
    for (int i = 30; i < 42; i++) run_period(mix(i), 1'b1);
    // drain
    for (int i = 0; i < 3; i++) run_period('1, 1'b0);
    // R8 every expected word delivered
    chk(expq.size() == 0, "R8 words left undelivered", expq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule